// File: doc/BRIEF.md
# Interleaved ADC Sampling Trigger Generator

This block issues start-of-conversion strobes for the current-sense converters of a multi-phase switching regulator with up to four phases. It runs one shared carrier position counter and, for each phase, shifts that position by an equal fraction of the carrier cycle. It then compares the shifted position with points computed from the phase's duty reference. The selected points are the middle of the PWM on-interval, the middle of the off-interval, or both. A sample taken there reads the average inductor current and stays away from the noise at the switching edges.

The carrier is either a sawtooth that steps through positions 0 to period-1, or a triangle that takes a full cycle of 2·period positions. A carrier state machine tracks the ramp and has three states. CAR_SAW is the sawtooth ramp. CAR_RISE is the up-slope of the triangle, positions 0 to period-1. CAR_FALL is the down-slope, positions period to 2·period-1. The transitions are as follows. Select-triangle moves the machine from CAR_SAW into CAR_RISE or CAR_FALL, depending on the next position. Apex moves CAR_RISE to CAR_FALL when the next position reaches period. Valley-wrap moves CAR_FALL to CAR_RISE when the position returns to 0. Select-sawtooth moves either triangle state back to CAR_SAW. Each phase registers its compare result once, so a strobe appears one clock after the matching position. The output polarity can be selected.

Top module: `adc_trig_gen`

## Requirements
- R1: While rst_n is low, the carrier position is 0 and every trigger output sits at its inactive level, which is the inverse of pol_hi.
- R2: With sym_mode=0 (sawtooth), the carrier position advances by one each clock from 0 to period-1 and then wraps to 0. The cycle length L equals period, and the machine stays in CAR_SAW.
- R3: With sym_mode=1 (triangle), the cycle length L equals 2·period. The machine is in CAR_RISE while the position is below period and in CAR_FALL while it is at or above period.
- R4: With n = phase_sel+1, phase k uses position (base + floor(k·L/n)) mod L, where base is the shared carrier position.
- R5: With samp_mode bit 0 set (codes 01 and 11), phase k fires at its on-interval midpoint. For the sawtooth this is position floor(duty_k/2); for the triangle it is position 0 (the valley).
- R6: With samp_mode bit 1 set (codes 10 and 11), phase k fires at its off-interval midpoint. For the sawtooth this is position floor((duty_k+period)/2); for the triangle it is position period (the peak).
- R7: With samp_mode=00, no trigger ever fires.
- R8: Phases k ≥ phase_sel+1 never fire. The codes are 00 for one phase, 01 for two, 10 for three and 11 for four.
- R9: With pol_hi=1 a firing trigger is driven 1 and an idle one 0. With pol_hi=0 the levels are inverted.
- R10: A trigger becomes active in the clock after the phase position matches, and it lasts exactly one clock when period ≥ 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_hi | input | 1 | 1: triggers active high, 0: active low |
| phase_sel | input | 2 | Number of active phases minus one |
| sym_mode | input | 1 | 1: triangle carrier, 0: sawtooth carrier |
| period | input | 12 | Carrier period in clocks (sawtooth cycle length) |
| duty_ref | input | 4x12 | Duty reference of each phase, phase 0 in the low word |
| samp_mode | input | 2 | Bit 0: sample in on-interval, bit 1: sample in off-interval |
| trig | output | 4 | Per-phase start-of-conversion strobes |

## Verification
Every cycle, the assertions check that the carrier position stays inside its cycle and that the triangle states agree with the position. They also check that disabled phases stay silent, that a strobe never lasts two clocks, and that a disabled sampling mode holds every output at the idle level. Only the bench's sweeps can show that each strobe lands at the right position. That covers the phase offset, the on-interval and off-interval midpoints of both carriers, and the one-clock latency; no per-cycle invariant can express that timing. The bench sweeps every phase count, mode, carrier and polarity over several small periods and many duty values.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int unsigned VAL_W = 12;
    localparam int unsigned NPH   = 4;
    localparam int unsigned SEL_W = $clog2(NPH);

    typedef enum logic [1:0] {
        CAR_SAW  = 2'd0,
        CAR_RISE = 2'd1,
        CAR_FALL = 2'd2
    } car_state_e;
endpackage

// File: rtl/carrier_fsm.sv
module carrier_fsm
    import adc_trig_pkg::*;
#(
    parameter int unsigned W = VAL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sym_mode,
    input  logic [W-1:0] period,
    output logic [W:0]   pos_q,
    output logic [W:0]   cyc_len,
    output car_state_e   state_q
);
    localparam int unsigned LW = W + 1;

    car_state_e   state_n;
    logic [LW-1:0] pos_n;
    logic [LW:0]   step;
    logic [LW-1:0] per_ext;

    assign per_ext = {1'b0, period};
    assign cyc_len = sym_mode ? {period, 1'b0} : per_ext;
    assign step    = {1'b0, pos_q} + 1'b1;

    always_comb begin
        if (cyc_len == '0)
            pos_n = '0;
        else if (step >= {1'b0, cyc_len})
            pos_n = '0;
        else
            pos_n = step[LW-1:0];
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CAR_SAW: begin
                if (sym_mode)
                    state_n = (pos_n < per_ext) ? CAR_RISE : CAR_FALL;
            end
            CAR_RISE: begin
                if (!sym_mode)
                    state_n = CAR_SAW;
                else if (pos_n >= per_ext)
                    state_n = CAR_FALL;
            end
            CAR_FALL: begin
                if (!sym_mode)
                    state_n = CAR_SAW;
                else if (pos_n < per_ext)
                    state_n = CAR_RISE;
            end
            default: state_n = CAR_SAW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAR_SAW;
            pos_q   <= '0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
        end
    end

    // R2
    pos_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0 && $stable(period) && $stable(sym_mode)) |-> pos_q < cyc_len);

    // R3
    slope_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_mode && $stable(sym_mode) && $stable(period) && period != '0)
            |-> ((state_q == CAR_FALL) == (pos_q >= per_ext)));
endmodule

// File: rtl/phase_tap.sv
module phase_tap
    import adc_trig_pkg::*;
#(
    parameter int unsigned W    = VAL_W,
    parameter int unsigned SELW = SEL_W,
    parameter int unsigned K    = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W:0]      base_pos,
    input  logic [W:0]      cyc_len,
    input  logic [W-1:0]    period,
    input  logic [W-1:0]    duty,
    input  logic            sym_mode,
    input  logic [SELW-1:0] phase_sel,
    input  logic [1:0]      samp_mode,
    output logic            strobe_q
);
    localparam int unsigned PW = W + 1 + SELW;
    localparam int unsigned CW = W + 2;
    localparam logic [SELW:0] KIDX = (SELW + 1)'(K);

    logic          enable;
    logic [PW-1:0] prod;
    logic [PW-1:0] shift_w;
    logic [CW-1:0] pos_raw;
    logic [CW-1:0] pos;
    logic [CW-1:0] on_pt;
    logic [CW-1:0] off_pt;
    logic [CW-1:0] len_ext;
    logic [W:0]    mid_sum;
    logic          hit;

    assign enable  = KIDX <= {1'b0, phase_sel};
    assign prod    = PW'(cyc_len) * PW'(K);
    assign shift_w = prod / PW'({1'b0, phase_sel} + 1'b1);
    assign len_ext = CW'(cyc_len);
    assign pos_raw = CW'(base_pos) + CW'(shift_w);
    assign pos     = (pos_raw >= len_ext) ? pos_raw - len_ext : pos_raw;
    assign mid_sum = {1'b0, duty} + {1'b0, period};
    assign on_pt   = sym_mode ? '0 : CW'(duty >> 1);
    assign off_pt  = sym_mode ? CW'(period) : CW'(mid_sum >> 1);
    assign hit     = enable && ((samp_mode[0] && pos == on_pt) ||
                                (samp_mode[1] && pos == off_pt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= hit;
    end

    // R8
    inactive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $stable(phase_sel)) |-> !strobe_q);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && period >= W'(4) && $stable(period) && $stable(sym_mode) &&
         $stable(phase_sel) && $stable(duty) && $stable(samp_mode)) |=> !strobe_q);
endmodule

// File: rtl/adc_trig_gen.sv
module adc_trig_gen
    import adc_trig_pkg::*;
#(
    parameter int unsigned W    = VAL_W,
    parameter int unsigned NP   = NPH,
    parameter int unsigned SELW = SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pol_hi,
    input  logic [SELW-1:0]       phase_sel,
    input  logic                  sym_mode,
    input  logic [W-1:0]          period,
    input  logic [NP-1:0][W-1:0]  duty_ref,
    input  logic [1:0]            samp_mode,
    output logic [NP-1:0]         trig
);
    logic [W:0]    base_pos;
    logic [W:0]    cyc_len;
    car_state_e    car_state;
    logic [NP-1:0] strobes;

    carrier_fsm #(.W(W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_mode (sym_mode),
        .period   (period),
        .pos_q    (base_pos),
        .cyc_len  (cyc_len),
        .state_q  (car_state)
    );

    for (genvar k = 0; k < NP; k++) begin : g_tap
        phase_tap #(.W(W), .SELW(SELW), .K(k)) u_tap (
            .clk       (clk),
            .rst_n     (rst_n),
            .base_pos  (base_pos),
            .cyc_len   (cyc_len),
            .period    (period),
            .duty      (duty_ref[k]),
            .sym_mode  (sym_mode),
            .phase_sel (phase_sel),
            .samp_mode (samp_mode),
            .strobe_q  (strobes[k])
        );
    end

    always_comb begin
        trig = pol_hi ? strobes : ~strobes;
    end

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_mode == 2'b00 && $stable(samp_mode)) |-> trig == {NP{~pol_hi}});
endmodule

// File: tb/tb_adc_trig_gen.sv
module tb_adc_trig_gen;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pol_hi = 1'b1;
    logic [1:0]       phase_sel = 2'd0;
    logic             sym_mode = 1'b0;
    logic [11:0]      period = 12'd6;
    logic [3:0][11:0] duty_ref = '0;
    logic [1:0]       samp_mode = 2'd0;
    logic [3:0]       trig;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    adc_trig_gen dut (
        .clk(clk), .rst_n(rst_n), .pol_hi(pol_hi), .phase_sel(phase_sel),
        .sym_mode(sym_mode), .period(period), .duty_ref(duty_ref),
        .samp_mode(samp_mode), .trig(trig)
    );

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    task automatic chk(input bit act, input bit exp, input string tag, input int k, input int j);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s phase=%0d step=%0d P=%0d sym=%0b sel=%0d mode=%0d pol=%0b actual=%0b expected=%0b",
                     tag, k, j, period, sym_mode, phase_sel, samp_mode, pol_hi, act, exp);
        end
    endtask

    // R2 R3: cycle length, R4: phase offset, R5 R6: midpoints, R7 R8: silence
    function automatic bit exp_hit(input int k, input int j, output string tag);
        int p, l, n, off, pos, onp, offp;
        bit h;
        p = period; l = sym_mode ? 2*p : p; n = phase_sel + 1;
        if (k >= n) begin tag = "R8"; return 1'b0; end
        off = (k * l) / n;
        pos = ((j - 1) % l + off) % l;
        onp  = sym_mode ? 0 : duty_ref[k] / 2;
        offp = sym_mode ? p : (duty_ref[k] + p) / 2;
        h = 1'b0;
        tag = (samp_mode == 2'b00) ? "R7" : (sym_mode ? "R3" : "R2");
        if (samp_mode[0] && pos == onp)  begin h = 1'b1; tag = "R5"; end
        if (samp_mode[1] && pos == offp) begin h = 1'b1; tag = "R6"; end
        if (!h && samp_mode != 2'b00 && k > 0) tag = "R4";
        return h;
    endfunction

    task automatic run_cfg(input int p, input bit s, input int ps, input int m, input bit pol, input int seed);
        int l;
        string tag;
        bit h;
        @(negedge clk);
        rst_n = 1'b0;
        period = 12'(p); sym_mode = s; phase_sel = 2'(ps); samp_mode = 2'(m); pol_hi = pol;
        for (int k = 0; k < 4; k++) duty_ref[k] = 12'((k * 3 + seed) % (p + 1));
        repeat (2) @(negedge clk);
        // R1: reset level is the inverse of pol_hi
        for (int k = 0; k < 4; k++) chk(trig[k], ~pol, "R1", k, 0);
        rst_n = 1'b1;
        l = s ? 2*p : p;
        for (int j = 1; j <= 2*l + 2; j++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                h = exp_hit(k, j, tag);
                // R9 polarity applied, R10 one-clock latency and width
                chk(trig[k], pol ? h : ~h, tag, k, j);
            end
        end
    endtask

    initial begin
        int seed;
        int plist[3];
        plist = '{6, 7, 10};
        seed = 0;
        for (int pi = 0; pi < 3; pi++)
            for (int s = 0; s < 2; s++)
                for (int ps = 0; ps < 4; ps++)
                    for (int m = 0; m < 4; m++)
                        for (int pol = 0; pol < 2; pol++) begin
                            run_cfg(plist[pi], s[0], ps, m, pol[0], seed);
                            seed++;
                        end
        report();
        $finish;
    end
endmodule